// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block turns one fast system clock into a set of aligned clock-enable strobes for a processor subsystem. A core/bus strobe fires once every 2^k system cycles. Two peripheral bus strobes, one for a slow bus and one for a fast bus, are derived from it. Each peripheral bus has a companion timer strobe that runs at the bus rate or at twice that rate. A free-running tick for the core system timer fires once per eight core strobes. All strobes are single-cycle enables in the system clock domain. Downstream logic qualifies its flops with them, so no derived clock nets are needed.

Ratios are given as log2 codes on three input fields and may change at any time. A new setting is held back until a cycle in which every strobe, under both the old and the new ratios, fires together. As a result, no strobe ever shows an interval shorter or longer than one of its two legal periods. One wrap-around counter drives every strobe, so all of them stay phase-aligned by construction.

Top module: `bus_clk_divider`

## Requirements
- R1: `core_en` fires once every 2^`core_code` system cycles for codes 0 to 9. Any code above 9 acts as 9, which gives a period of 512.
- R2: `slow_bus_en` fires once every 2^(c+s) system cycles and `fast_bus_en` once every 2^(c+f) system cycles. Here c is the effective core code, and s and f are `slow_code` and `fast_code`. Valid bus codes are 0 to 4, and any bus code above 4 acts as 4, which gives a period of 16.
- R3: Neither bus strobe ever asserts in a cycle where `core_en` is low.
- R4: For each bus, the timer strobe equals the bus strobe when the bus code is 0. For a nonzero bus code, the timer strobe fires at half the bus period, which is twice the rate. In every case the timer strobe is high whenever its bus strobe is high.
- R5: `tick_en` fires once every 8 core periods, that is every 2^(c+3) system cycles. It is never high while `core_en` is low.
- R6: After a ratio change, every interval between two consecutive assertions of a strobe equals either its old period or its new period. Once the new period appears, the old period does not return.
- R7: While reset is asserted, and in the first cycle after release, all six strobes are high, because the counter is cleared and every ratio is 1. Codes present at release take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_code | input | 4 | log2 of the core divide ratio (0..9, clamped) |
| slow_code | input | 3 | log2 of the slow bus ratio relative to core (0..4, clamped) |
| fast_code | input | 3 | log2 of the fast bus ratio relative to core (0..4, clamped) |
| core_en | output | 1 | Core/bus clock enable strobe |
| slow_bus_en | output | 1 | Slow peripheral bus enable strobe |
| fast_bus_en | output | 1 | Fast peripheral bus enable strobe |
| slow_tim_en | output | 1 | Slow-bus timer enable strobe |
| fast_tim_en | output | 1 | Fast-bus timer enable strobe |
| tick_en | output | 1 | System timer tick strobe (core / 8) |

## Verification
The bench drives out-of-range codes on every field. A design that does not clamp them would wrap to a short period or stall a strobe entirely.

It also switches the core ratio in the middle of a long period, in both directions. A design that applies the new ratio at once would produce an odd interval, for example 6 cycles between a 16-cycle period and a 2-cycle period.

Bus code 0 is checked against a nonzero code to catch a timer strobe that is always doubled. Coincidence of the bus, timer and tick strobes with the core strobe is checked across long runs.

Reset is released with nonzero codes already applied. This exposes a design that does not start from a common all-strobes-high edge.

// File: rtl/bus_clk_divider.sv
module bus_clk_divider #(
  parameter int CORE_MAX = 9,
  parameter int BUS_MAX  = 4,
  parameter int TICK_LOG = 3,
  localparam int CW_CODE = $clog2(CORE_MAX + 1),
  localparam int BW_CODE = $clog2(BUS_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW_CODE-1:0] core_code,
  input  logic [BW_CODE-1:0] slow_code,
  input  logic [BW_CODE-1:0] fast_code,
  output logic               core_en,
  output logic               slow_bus_en,
  output logic               fast_bus_en,
  output logic               slow_tim_en,
  output logic               fast_tim_en,
  output logic               tick_en
);
  localparam int CNT_W = CORE_MAX + ((BUS_MAX > TICK_LOG) ? BUS_MAX : TICK_LOG);

  logic [CNT_W-1:0]   cnt;
  logic [CW_CODE-1:0] cur_c, req_c;
  logic [BW_CODE-1:0] cur_s, cur_f, req_s, req_f;
  int                 old_span, new_span, sync_span;
  logic               at_sync;

  function automatic logic low_zero(input logic [CNT_W-1:0] c, input int n);
    return (c & ~({CNT_W{1'b1}} << n)) == '0;
  endfunction

  function automatic int span(input int c, input int s, input int f);
    int m;
    m = TICK_LOG;
    if (s > m) m = s;
    if (f > m) m = f;
    return c + m;
  endfunction

  assign req_c = (int'(core_code) > CORE_MAX) ? CW_CODE'(CORE_MAX) : core_code;
  assign req_s = (int'(slow_code) > BUS_MAX)  ? BW_CODE'(BUS_MAX)  : slow_code;
  assign req_f = (int'(fast_code) > BUS_MAX)  ? BW_CODE'(BUS_MAX)  : fast_code;

  always_comb begin
    old_span  = span(int'(cur_c), int'(cur_s), int'(cur_f));
    new_span  = span(int'(req_c), int'(req_s), int'(req_f));
    sync_span = (old_span > new_span) ? old_span : new_span;
  end

  assign at_sync = low_zero(cnt, sync_span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cur_c <= '0;
      cur_s <= '0;
      cur_f <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (at_sync) begin
        cur_c <= req_c;
        cur_s <= req_s;
        cur_f <= req_f;
      end
    end
  end

  assign core_en     = low_zero(cnt, int'(cur_c));
  assign slow_bus_en = low_zero(cnt, int'(cur_c) + int'(cur_s));
  assign fast_bus_en = low_zero(cnt, int'(cur_c) + int'(cur_f));
  assign slow_tim_en = low_zero(cnt, (cur_s == '0) ? int'(cur_c) : int'(cur_c) + int'(cur_s) - 1);
  assign fast_tim_en = low_zero(cnt, (cur_f == '0) ? int'(cur_c) : int'(cur_c) + int'(cur_f) - 1);
  assign tick_en     = low_zero(cnt, int'(cur_c) + TICK_LOG);
endmodule

// File: rtl/bus_clk_divider_chk.sv
module bus_clk_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic core_en,
  input logic slow_bus_en,
  input logic fast_bus_en,
  input logic slow_tim_en,
  input logic fast_tim_en,
  input logic tick_en
);
  a_r3_slow_in_core: assert property (@(posedge clk) disable iff (!rst_n)
    slow_bus_en |-> core_en);
  a_r3_fast_in_core: assert property (@(posedge clk) disable iff (!rst_n)
    fast_bus_en |-> core_en);
  a_r4_slow_bus_in_tim: assert property (@(posedge clk) disable iff (!rst_n)
    slow_bus_en |-> slow_tim_en);
  a_r4_fast_bus_in_tim: assert property (@(posedge clk) disable iff (!rst_n)
    fast_bus_en |-> fast_tim_en);
  a_r5_tick_in_core: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> core_en);
endmodule

bind bus_clk_divider bus_clk_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en),
  .slow_bus_en(slow_bus_en), .fast_bus_en(fast_bus_en),
  .slow_tim_en(slow_tim_en), .fast_tim_en(fast_tim_en), .tick_en(tick_en)
);

// File: tb/bus_clk_divider_test.sv
module bus_clk_divider_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] core_code = 0;
  logic [2:0] slow_code = 0, fast_code = 0;
  logic core_en, slow_bus_en, fast_bus_en, slow_tim_en, fast_tim_en, tick_en;
  logic [5:0] en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_clk_divider uut (.*);

  assign en = {tick_en, fast_tim_en, slow_tim_en, fast_bus_en, slow_bus_en, core_en};

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_codes(int c, int s, int f);
    core_code = 4'(c); slow_code = 3'(s); fast_code = 3'(f);
    repeat (8200) @(negedge clk);
  endtask

  task automatic period(int i, int exp, string req);
    int n = 0;
    @(negedge clk);
    while (!en[i]) @(negedge clk);
    do begin @(negedge clk); n++; end while (!en[i]);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    core_code = 3; slow_code = 1; fast_code = 0;
    repeat (3) @(negedge clk);
    check(en == 6'h3f, "R7 during reset", int'(en), 63);
    rst_n = 1;
    #1 check(en == 6'h3f, "R7 first cycle", int'(en), 63);
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!core_en);
      check(n == 8, "R7 codes applied after release", n, 8);
    end
  endtask

  task automatic t_unity;
    set_codes(0, 0, 0);
    period(0, 1, "R1 core code0");
    period(1, 1, "R2 slow code0");
    period(3, 1, "R4 slow tim code0");
    period(5, 8, "R5 tick code0");
  endtask

  task automatic t_mid;
    int bad_bus = 0, bad_tim = 0, bad_tick = 0;
    set_codes(3, 2, 0);
    period(0, 8, "R1 core code3");
    period(1, 32, "R2 slow code2");
    period(2, 8, "R2 fast code0");
    period(3, 16, "R4 slow tim doubled");
    period(4, 8, "R4 fast tim equal");
    period(5, 64, "R5 tick");
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ((slow_bus_en || fast_bus_en) && !core_en) bad_bus++;
      if ((slow_bus_en && !slow_tim_en) || (fast_bus_en && !fast_tim_en)) bad_tim++;
      if (tick_en && !core_en) bad_tick++;
    end
    check(bad_bus == 0, "R3 bus within core", bad_bus, 0);
    check(bad_tim == 0, "R4 bus within timer", bad_tim, 0);
    check(bad_tick == 0, "R5 tick within core", bad_tick, 0);
  endtask

  task automatic t_clamp;
    set_codes(12, 7, 1);
    period(0, 512, "R1 core clamp");
    period(1, 8192, "R2 slow clamp");
    period(2, 1024, "R2 fast code1");
    period(3, 4096, "R4 slow tim clamp");
    period(4, 512, "R4 fast tim code1");
    period(5, 4096, "R5 tick at 512");
  endtask

  task automatic t_switch(int from_c, int to_c);
    int p_old = 1 << from_c, p_new = 1 << to_c;
    int n = 0, bad = 0, seen_new = 0, seen_old = 0;
    set_codes(from_c, 0, 0);
    @(negedge clk);
    while (!core_en) @(negedge clk);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      n++;
      if (k == 5) core_code = 4'(to_c);
      if (core_en) begin
        if (n == p_new) seen_new = 1;
        else if (n == p_old && !seen_new) seen_old = 1;
        else bad++;
        n = 0;
      end
    end
    check(bad == 0, "R6 no odd interval", bad, 0);
    check(seen_old == 1 && seen_new == 1, "R6 both periods seen", seen_old + seen_new, 2);
  endtask

  initial begin
    t_reset();
    t_unity();
    t_mid();
    t_clamp();
    t_switch(4, 1);
    t_switch(1, 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule